// File: doc/BRIEF.md
# Downlink Shared-Channel Reference-Signal Pattern Generator

This block works out where the demodulation reference signals of one downlink shared-channel allocation sit inside a 14-symbol slot. A caller presents a configuration and pulses `start`. The configuration holds the signal type, the mapping type, the allocation start symbol and length, the additional-position level, single or double symbol mode, the broadcast first-position choice and the count of CDM groups without data. The block decodes the configuration once, at the `start` edge. It then walks the slot at one symbol per clock. For each symbol it reports whether that symbol carries reference signals, together with a 12-bit mask of the subcarriers used inside one PRB.

The block keeps an internal table of additional reference positions for single and double symbol mode and for both mapping types. The table covers durations up to 14 symbols and additional-position levels 0 to 3. Any combination the table does not define is flagged on `cfg_err`, and no reference symbols or subcarriers are reported for that slot. Sequence generation and resource-element mapping take place elsewhere.

Top module: `dmrs_pattern_gen`

## Requirements
- R1: While `rst` is high and after reset, `sym_valid`, `is_ref`, `done` and `cfg_err` are 0 and `sc_mask` is all zeros.
- R2: A `start` sampled while no walk is running begins a walk. `sym_valid` is 1 for the next 14 cycles, with `sym_idx` counting 0 to 13. `done` is 1 for exactly one cycle after symbol 13. A `start` seen during a walk is ignored.
- R3: For mapping type A (`map_type_b`=0), the first reference symbol is slot symbol 3 when `first_pos3`=1 and slot symbol 2 otherwise. The table duration is start + length, and table positions count from the slot start.
- R4: For mapping type B (`map_type_b`=1), the first reference symbol is the allocation start symbol. The table duration is the allocation length, and table positions count from the allocation start.
- R5: Extra positions for single symbol mode are taken from the table by duration and `add_pos` (0 to 3). For example, type A at duration 14 with `add_pos`=2 gives 7 and 11, and type B at duration 7 with `add_pos`=1 gives 4.
- R6: In double symbol mode (`dbl_sym`=1), every position p also marks p+1. For example, type B with start 3, length 10 and `add_pos`=1 gives symbols 3, 4, 10 and 11.
- R7: With `ref_type`=0 (type 1), the mask sets bit 4n+2k′+Δ for n in 0..2 and k′ in 0..1. Δ is {0} when `cdm_groups`=1, giving 0x555, and {0,1} otherwise, giving 0xFFF. Bit i of `sc_mask` stands for subcarrier i.
- R8: With `ref_type`=1 (type 2), the mask sets bit 6n+k′+Δ for n and k′ in 0..1. Δ is {0}, {0,2} or {0,2,4} for `cdm_groups` of 1, 2 or 3, giving 0x0C3, 0x3CF or 0xFFF.
- R9: A symbol outside the range from start to start+length−1 never has `is_ref`=1, even when it is a reference position.
- R10: `cfg_err` is 1 for the walk, and `is_ref` stays 0 with `sc_mask` zero, when any of these holds: the duration is not in the table (type A single 3..14, type B single 2..13, type A double 5..14, type B double 5..13); double mode with `add_pos`≥2; length 0; start+length>14; `cdm_groups`=0; type A with `first_pos3`=1 and `add_pos`=3.
- R11: `sc_mask` and `cfg_err` keep their values for the whole walk and until the next accepted `start`.
- R12: A `start` given in the cycle in which `done` is 1 is accepted. Symbol 0 of the new walk follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a slot walk with the present configuration |
| ref_type | input | 1 | 0 = reference type 1, 1 = reference type 2 |
| map_type_b | input | 1 | 0 = mapping type A, 1 = mapping type B |
| alloc_start | input | 4 | First symbol of the allocation |
| alloc_len | input | 4 | Allocation length in symbols |
| add_pos | input | 2 | Additional-position level 0..3 |
| dbl_sym | input | 1 | 1 = double symbol mode |
| first_pos3 | input | 1 | Type A first symbol: 1 = symbol 3, 0 = symbol 2 |
| cdm_groups | input | 2 | CDM groups without data, 1..3 |
| sym_valid | output | 1 | Walk in progress; `sym_idx` is meaningful |
| sym_idx | output | 4 | Current slot symbol |
| is_ref | output | 1 | Current symbol carries reference signals |
| sc_mask | output | 12 | Subcarrier mask within one PRB |
| done | output | 1 | One-cycle pulse after symbol 13 |
| cfg_err | output | 1 | Latched configuration is invalid |

## Verification
The end-of-slot `done` pulse and the acceptance of a new `start` can fall in the same cycle. The bench provokes this by raising `start`, with a new configuration, in exactly the cycle where `done` is seen. It then expects symbol 0 of the new walk, with the new mask, in the following cycle, and no gap. The bench also raises `start` in the middle of a walk and expects the walk to go on with its original pattern. Every cycle is compared against a behavioural model that keeps its own position lists.

// File: rtl/dmrs_pkg.sv
package dmrs_pkg;

    localparam int SLOT_SYMS  = 14;
    localparam int SC_PER_PRB = 12;
    localparam int SYM_W      = $clog2(SLOT_SYMS);

    typedef logic [SLOT_SYMS-1:0]  sym_mask_t;
    typedef logic [SC_PER_PRB-1:0] sc_mask_t;

    typedef enum logic { REF_T1 = 1'b0, REF_T2 = 1'b1 } ref_type_e;
    typedef enum logic { MAP_A  = 1'b0, MAP_B  = 1'b1 } map_type_e;

    typedef struct packed {
        ref_type_e   rtype;
        map_type_e   mtype;
        logic [3:0]  start;
        logic [3:0]  len;
        logic [1:0]  add_pos;
        logic        dbl;
        logic        first3;
        logic [1:0]  cdm;
    } dmrs_cfg_t;

    typedef struct packed {
        logic      ok;
        sym_mask_t extra;
    } pos_lookup_t;

    function automatic sym_mask_t pb(int p);
        sym_mask_t m;
        m = '0;
        if (p >= 0 && p < SLOT_SYMS) m[p] = 1'b1;
        return m;
    endfunction

    // single symbol, mapping type A (positions from slot start)
    function automatic pos_lookup_t tbl_single_a(int ld, int ap);
        pos_lookup_t r;
        r.ok    = (ld >= 3) && (ld <= 14);
        r.extra = '0;
        if (ap >= 1) begin
            if (ld == 8 || ld == 9)
                r.extra = pb(7);
            else if (ld >= 10 && ld <= 12)
                r.extra = (ap == 1) ? pb(9) :
                          (ap == 2 || ld < 12) ? (pb(6) | pb(9)) :
                          (pb(5) | pb(8) | pb(11));
            else if (ld >= 13)
                r.extra = (ap == 1) ? pb(11) :
                          (ap == 2) ? (pb(7) | pb(11)) :
                          (pb(5) | pb(8) | pb(11));
        end
        return r;
    endfunction

    // single symbol, mapping type B (positions from allocation start)
    function automatic pos_lookup_t tbl_single_b(int ld, int ap);
        pos_lookup_t r;
        r.ok    = (ld >= 2) && (ld <= 13);
        r.extra = '0;
        if (ap >= 1) begin
            if (ld >= 5 && ld <= 7)
                r.extra = pb(4);
            else if (ld == 8)
                r.extra = (ap == 1) ? pb(6) : (pb(3) | pb(6));
            else if (ld == 9 || ld == 10)
                r.extra = (ap == 1) ? pb(7) : (pb(4) | pb(7));
            else if (ld == 11)
                r.extra = (ap == 1) ? pb(8) :
                          (ap == 2) ? (pb(4) | pb(8)) :
                          (pb(3) | pb(6) | pb(9));
            else if (ld >= 12)
                r.extra = (ap == 1) ? pb(9) :
                          (ap == 2) ? (pb(5) | pb(9)) :
                          (pb(3) | pb(6) | pb(9));
        end
        return r;
    endfunction

    function automatic pos_lookup_t tbl_double_a(int ld, int ap);
        pos_lookup_t r;
        r.ok    = (ld >= 5) && (ld <= 14) && (ap < 2);
        r.extra = '0;
        if (ap == 1) begin
            if (ld >= 10 && ld <= 12) r.extra = pb(8);
            else if (ld >= 13)        r.extra = pb(10);
        end
        return r;
    endfunction

    function automatic pos_lookup_t tbl_double_b(int ld, int ap);
        pos_lookup_t r;
        r.ok    = (ld >= 5) && (ld <= 13) && (ap < 2);
        r.extra = '0;
        if (ap == 1) begin
            if (ld == 8 || ld == 9)        r.extra = pb(5);
            else if (ld == 10 || ld == 11) r.extra = pb(7);
            else if (ld >= 12)             r.extra = pb(8);
        end
        return r;
    endfunction

    // subcarrier pattern from the per-type index formula
    function automatic sc_mask_t build_sc(ref_type_e t, logic [1:0] cdm);
        sc_mask_t m;
        m = '0;
        if (t == REF_T1) begin
            for (int n = 0; n < 3; n++)
                for (int kp = 0; kp < 2; kp++)
                    for (int d = 0; d < 2; d++)
                        if (d == 0 || cdm != 2'd1) m[4*n + 2*kp + d] = 1'b1;
        end else begin
            for (int n = 0; n < 2; n++)
                for (int kp = 0; kp < 2; kp++)
                    for (int g = 0; g < 3; g++)
                        if (g < int'(cdm)) m[6*n + kp + 2*g] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dmrs_sym_decode.sv
module dmrs_sym_decode
    import dmrs_pkg::*;
(
    input  dmrs_cfg_t cfg,
    output sym_mask_t syms,
    output logic      err
);
    pos_lookup_t look;
    sym_mask_t   rel, rel2, absm, win;
    int          ld, l0, st, ln;

    always_comb begin
        st = int'(cfg.start);
        ln = int'(cfg.len);
        ld = (cfg.mtype == MAP_A) ? (st + ln) : ln;
        l0 = (cfg.mtype == MAP_A) ? (cfg.first3 ? 3 : 2) : 0;

        unique case ({cfg.dbl, cfg.mtype})
            {1'b0, MAP_A}: look = tbl_single_a(ld, int'(cfg.add_pos));
            {1'b0, MAP_B}: look = tbl_single_b(ld, int'(cfg.add_pos));
            {1'b1, MAP_A}: look = tbl_double_a(ld, int'(cfg.add_pos));
            default:       look = tbl_double_b(ld, int'(cfg.add_pos));
        endcase

        rel  = look.extra | pb(l0);
        rel2 = cfg.dbl ? (rel | (rel << 1)) : rel;
        absm = (cfg.mtype == MAP_A) ? rel2 : (rel2 << cfg.start);

        for (int i = 0; i < SLOT_SYMS; i++)
            win[i] = (i >= st) && (i < st + ln);

        err = !look.ok || (ln == 0) || (st + ln > SLOT_SYMS) || (cfg.cdm == 2'd0) ||
              (cfg.mtype == MAP_A && cfg.first3 && cfg.add_pos == 2'd3);

        syms = err ? '0 : (absm & win);
    end
endmodule

// File: rtl/dmrs_sc_decode.sv
module dmrs_sc_decode
    import dmrs_pkg::*;
(
    input  dmrs_cfg_t cfg,
    output sc_mask_t  sc
);
    always_comb sc = build_sc(cfg.rtype, cfg.cdm);
endmodule

// File: rtl/dmrs_slot_walker.sv
module dmrs_slot_walker #(
    parameter int NUM_SYM = 14,
    localparam int IDX_W  = $clog2(NUM_SYM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             accept,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SYM - 1);

    assign accept = start && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= active && (idx == LAST);
            if (active) begin
                if (idx == LAST) active <= 1'b0;
                else             idx    <= idx + 1'b1;
            end else if (start) begin
                active <= 1'b1;
                idx    <= '0;
            end
        end
    end
endmodule

// File: rtl/dmrs_pattern_gen.sv
module dmrs_pattern_gen
    import dmrs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  ref_type,
    input  logic                  map_type_b,
    input  logic [3:0]            alloc_start,
    input  logic [3:0]            alloc_len,
    input  logic [1:0]            add_pos,
    input  logic                  dbl_sym,
    input  logic                  first_pos3,
    input  logic [1:0]            cdm_groups,
    output logic                  sym_valid,
    output logic [SYM_W-1:0]      sym_idx,
    output logic                  is_ref,
    output logic [SC_PER_PRB-1:0] sc_mask,
    output logic                  done,
    output logic                  cfg_err
);
    dmrs_cfg_t cfg;
    sym_mask_t dec_syms, pat_q;
    sc_mask_t  dec_sc, sc_q;
    logic      dec_err, err_q, accept;

    always_comb begin
        cfg.rtype   = ref_type_e'(ref_type);
        cfg.mtype   = map_type_e'(map_type_b);
        cfg.start   = alloc_start;
        cfg.len     = alloc_len;
        cfg.add_pos = add_pos;
        cfg.dbl     = dbl_sym;
        cfg.first3  = first_pos3;
        cfg.cdm     = cdm_groups;
    end

    dmrs_sym_decode u_sym (.cfg(cfg), .syms(dec_syms), .err(dec_err));
    dmrs_sc_decode  u_sc  (.cfg(cfg), .sc(dec_sc));

    dmrs_slot_walker #(.NUM_SYM(SLOT_SYMS)) u_walk (
        .clk(clk), .rst(rst), .start(start), .accept(accept),
        .active(sym_valid), .idx(sym_idx), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
            sc_q  <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            pat_q <= dec_syms;
            sc_q  <= dec_err ? '0 : dec_sc;
            err_q <= dec_err;
        end
    end

    assign is_ref  = sym_valid && pat_q[sym_idx];
    assign sc_mask = sc_q;
    assign cfg_err = err_q;
endmodule

// File: rtl/dmrs_pattern_chk.sv
module dmrs_pattern_chk
    import dmrs_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  sym_valid,
    input logic [SYM_W-1:0]      sym_idx,
    input logic                  is_ref,
    input logic [SC_PER_PRB-1:0] sc_mask,
    input logic                  done,
    input logic                  cfg_err
);
    localparam logic [SYM_W-1:0] LAST = SYM_W'(SLOT_SYMS - 1);

    a_r9_ref_inside_walk: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> sym_valid);

    a_r10_err_silent: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!is_ref && sc_mask == '0));

    a_r2_walk_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(sym_valid) |-> sym_idx == '0);

    a_r2_walk_steps: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_idx != LAST) |=> (sym_valid && sym_idx == SYM_W'($past(sym_idx) + 1'b1)));

    a_r2_done_follows_last: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_idx == LAST) |=> (done && !sym_valid));

    a_r2_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_mask_held: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_idx != '0) |-> ($stable(sc_mask) && $stable(cfg_err)));

    a_r12_restart_on_done: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (sym_valid && sym_idx == '0));
endmodule

bind dmrs_pattern_gen dmrs_pattern_chk u_chk (.*);

// File: tb/dmrs_pattern_gen_bench.sv
module dmrs_pattern_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ref_type = 1'b0, map_type_b = 1'b0, dbl_sym = 1'b0, first_pos3 = 1'b0;
    logic [3:0]  alloc_start = 4'd0, alloc_len = 4'd0;
    logic [1:0]  add_pos = 2'd0, cdm_groups = 2'd1;
    logic        sym_valid, is_ref, done, cfg_err;
    logic [3:0]  sym_idx;
    logic [11:0] sc_mask;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit mon_en = 1'b0;

    // behavioural model state
    bit        m_active, m_done, m_err;
    int        m_idx;
    bit [13:0] m_pat;
    bit [11:0] m_sc;
    bit [13:0] obs_syms;

    always #2 clk = ~clk;

    dmrs_pattern_gen u_dmrs_pattern_gen (.*);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // reference positions: queue of offsets, resolved against the allocation
    function automatic void ref_model(bit mb, bit dbl, int ap, int s, int l, bit f3,
                                      int cdm, bit rt, output bit err,
                                      output bit [13:0] pat, output bit [11:0] sc);
        int q[$];
        int ld = mb ? l : s + l;
        bit ok;
        q.push_back(mb ? 0 : (f3 ? 3 : 2));
        if (!dbl && !mb) begin
            ok = ld >= 3 && ld <= 14;
            if (ld inside {8, 9} && ap > 0) q.push_back(7);
            if (ld inside {10, 11} && ap > 0) begin
                if (ap > 1) q.push_back(6);
                q.push_back(9);
            end
            if (ld == 12 && ap == 1) q.push_back(9);
            if (ld == 12 && ap == 2) begin q.push_back(6); q.push_back(9); end
            if (ld >= 12 && ap == 3) begin q.push_back(5); q.push_back(8); q.push_back(11); end
            if (ld >= 13 && ap == 1) q.push_back(11);
            if (ld >= 13 && ap == 2) begin q.push_back(7); q.push_back(11); end
        end else if (!dbl) begin
            ok = ld >= 2 && ld <= 13;
            if (ld inside {[5:7]} && ap > 0) q.push_back(4);
            if (ld == 8 && ap > 0) begin if (ap > 1) q.push_back(3); q.push_back(6); end
            if (ld inside {9, 10} && ap > 0) begin if (ap > 1) q.push_back(4); q.push_back(7); end
            if (ld == 11) begin
                if (ap == 1) q.push_back(8);
                if (ap == 2) begin q.push_back(4); q.push_back(8); end
            end
            if (ld >= 12) begin
                if (ap == 1) q.push_back(9);
                if (ap == 2) begin q.push_back(5); q.push_back(9); end
            end
            if (ld >= 11 && ap == 3) begin q.push_back(3); q.push_back(6); q.push_back(9); end
        end else if (!mb) begin
            ok = ld >= 5 && ld <= 14 && ap < 2;
            if (ap == 1 && ld inside {[10:12]}) q.push_back(8);
            if (ap == 1 && ld >= 13) q.push_back(10);
        end else begin
            ok = ld >= 5 && ld <= 13 && ap < 2;
            if (ap == 1 && ld inside {8, 9}) q.push_back(5);
            if (ap == 1 && ld inside {10, 11}) q.push_back(7);
            if (ap == 1 && ld >= 12) q.push_back(8);
        end
        err = !ok || l == 0 || s + l > 14 || cdm == 0 || (!mb && f3 && ap == 3);
        pat = '0;
        sc  = '0;
        if (err) return;
        foreach (q[i]) begin
            for (int d = 0; d <= (dbl ? 1 : 0); d++) begin
                int a = (mb ? s : 0) + q[i] + d;
                if (a >= s && a < s + l) pat[a] = 1'b1;
            end
        end
        for (int i = 0; i < 12; i++)
            sc[i] = rt ? (((i % 6) / 2) < cdm) : (cdm == 1 ? (i % 2 == 0) : 1'b1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_done = 0; m_err = 0; m_idx = 0; m_pat = '0; m_sc = '0;
        end else begin
            m_done = m_active && m_idx == 13;
            if (m_active) begin
                if (m_idx == 13) m_active = 0;
                else m_idx++;
            end else if (start) begin
                m_active = 1; m_idx = 0; obs_syms = '0;
                ref_model(map_type_b, dbl_sym, int'(add_pos), int'(alloc_start),
                          int'(alloc_len), first_pos3, int'(cdm_groups), ref_type,
                          m_err, m_pat, m_sc);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && mon_en) begin
            chk(sym_valid == m_active, "R2", "sym_valid", sym_valid, m_active);
            if (m_active) chk(int'(sym_idx) == m_idx, "R2", "sym_idx", sym_idx, m_idx);
            chk(done == m_done, "R2", "done", done, m_done);
            chk(is_ref == (m_active && m_pat[m_idx]), "R5", "is_ref", is_ref,
                m_active && m_pat[m_idx]);
            chk(sc_mask == m_sc, ref_type ? "R8" : "R7", "sc_mask", sc_mask, m_sc);
            chk(cfg_err == m_err, "R10", "cfg_err", cfg_err, m_err);
            if (sym_valid && is_ref) obs_syms[sym_idx] = 1'b1;
        end
    end

    task automatic set_cfg(bit rt, bit mb, int s, int l, int ap, bit dbl, bit f3, int cdm);
        ref_type = rt; map_type_b = mb; alloc_start = 4'(s); alloc_len = 4'(l);
        add_pos = 2'(ap); dbl_sym = dbl; first_pos3 = f3; cdm_groups = 2'(cdm);
    endtask

    // leaves the bench at the negedge where done is visible
    task automatic run_slot(bit rt, bit mb, int s, int l, int ap, bit dbl, bit f3, int cdm);
        @(negedge clk);
        set_cfg(rt, mb, s, l, ap, dbl, f3, cdm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "R2", "watchdog expired", cyc, 150000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!sym_valid && !is_ref && !done && !cfg_err && sc_mask == 0, "R1", "reset outputs",
            {sym_valid, is_ref, done, cfg_err, sc_mask}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sym_valid && !is_ref && !done && !cfg_err && sc_mask == 0, "R1", "idle after reset",
            {sym_valid, is_ref, done, cfg_err, sc_mask}, 0);
        mon_en = 1'b1;

        // R3: type A, S=2, len 12, add_pos 2, single, two CDM groups
        run_slot(0, 0, 2, 12, 2, 0, 0, 2);
        chk(obs_syms == 14'h0884, "R3", "symbols A pos2", obs_syms, 14'h0884);
        chk(sc_mask == 12'hFFF, "R7", "type1 cdm2 mask", sc_mask, 12'hFFF);
        chk(done, "R2", "done after symbol 13", done, 1);
        run_slot(0, 0, 2, 12, 2, 0, 1, 2);
        chk(obs_syms == 14'h0888, "R3", "symbols A first 3", obs_syms, 14'h0888);

        // R4/R5: type B from allocation start
        run_slot(1, 1, 4, 7, 1, 0, 0, 1);
        chk(obs_syms == 14'h0110, "R4", "symbols B S4 L7", obs_syms, 14'h0110);
        chk(sc_mask == 12'h0C3, "R8", "type2 cdm1 mask", sc_mask, 12'h0C3);

        // R6: double symbol
        run_slot(1, 1, 3, 10, 1, 1, 0, 2);
        chk(obs_syms == 14'h0C18, "R6", "double B", obs_syms, 14'h0C18);
        chk(sc_mask == 12'h3CF, "R8", "type2 cdm2 mask", sc_mask, 12'h3CF);
        run_slot(0, 0, 0, 14, 1, 1, 0, 1);
        chk(obs_syms == 14'h0C0C, "R6", "double A", obs_syms, 14'h0C0C);
        chk(sc_mask == 12'h555, "R7", "type1 cdm1 mask", sc_mask, 12'h555);

        // R9: first type A symbol before the allocation is dropped
        run_slot(1, 0, 4, 10, 1, 0, 0, 3);
        chk(obs_syms == 14'h0800, "R9", "outside allocation", obs_syms, 14'h0800);
        chk(sc_mask == 12'hFFF, "R8", "type2 cdm3 mask", sc_mask, 12'hFFF);

        // R10: invalid combinations
        run_slot(0, 0, 0, 14, 2, 1, 0, 1);
        chk(cfg_err && obs_syms == 0 && sc_mask == 0, "R10", "double add_pos 2",
            {cfg_err, obs_syms, sc_mask}, 1 << 26);
        run_slot(0, 1, 10, 6, 0, 0, 0, 1);
        chk(cfg_err == 1, "R10", "past slot end", cfg_err, 1);
        run_slot(0, 0, 0, 12, 0, 0, 0, 0);
        chk(cfg_err == 1, "R10", "zero cdm groups", cfg_err, 1);
        run_slot(0, 0, 0, 14, 3, 0, 1, 2);
        chk(cfg_err == 1, "R10", "first 3 with add_pos 3", cfg_err, 1);

        // R2/R11: start during a walk is ignored
        @(negedge clk);
        set_cfg(0, 0, 2, 12, 2, 0, 0, 2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        set_cfg(1, 1, 0, 4, 0, 1, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sym_idx == 4'd6 && sym_valid, "R2", "start ignored mid walk", sym_idx, 6);
        repeat (8) @(negedge clk);
        chk(obs_syms == 14'h0884 && sc_mask == 12'hFFF && !cfg_err, "R11", "pattern kept",
            obs_syms, 14'h0884);

        // R12: start in the done cycle
        run_slot(0, 0, 2, 12, 2, 0, 0, 2);
        chk(done == 1, "R12", "done seen", done, 1);
        set_cfg(1, 1, 4, 7, 1, 0, 0, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sym_valid && sym_idx == 0, "R12", "back-to-back symbol 0", {sym_valid, sym_idx}, 16);
        chk(sc_mask == 12'h0C3, "R12", "new mask at once", sc_mask, 12'h0C3);
        repeat (14) @(negedge clk);
        chk(obs_syms == 14'h0110, "R12", "second walk symbols", obs_syms, 14'h0110);

        // sweep against the model
        for (int mb = 0; mb < 2; mb++)
            for (int dbl = 0; dbl < 2; dbl++)
                for (int ap = 0; ap < 4; ap++)
                    for (int si = 0; si < 4; si++)
                        for (int l = 1; l <= 14; l++) begin
                            int s = (si == 0) ? 0 : (si == 1) ? 2 : (si == 2) ? 3 : 5;
                            run_slot(1'((l + ap) % 2), 1'(mb), s, l, ap, 1'(dbl),
                                     1'(si % 2), 1 + (l % 3));
                        end

        finish_run();
    end
endmodule